// File: doc/BRIEF.md
# NaN Operand Screening Stage

This stage sits in front of an 80-bit extended-precision arithmetic datapath. Each operation brings up to two operands, a mask saying which of them the operation actually uses, and an operation-class code. The stage decides whether each used operand is a signalling NaN, a quiet NaN or an ordinary value. From that it works out three things: whether the invalid-operation condition is raised, whether the result must be replaced by a NaN, and which NaN to emit.

The operand format is one sign bit (bit 79), a 15-bit exponent (bits 78:64) and a 64-bit significand (bits 63:0) whose integer bit is explicit. A value is a NaN when its exponent is all ones and bits 62:0 are not all zero. A NaN is quiet when bit 62 is 1 and signalling when bit 62 is 0. An input flag reports a masked stack overflow on an operation that writes two results. The arithmetic itself, the register stack and any bus interface lie outside this block.

Operations enter on a valid/ready port and leave on a second valid/ready port one register later. A transfer happens on a rising edge where both valid and ready are high. While the output is held back, the output fields stay frozen and `in_ready` is low. An accepted operation reaches the output on the next edge, and a new operation can be accepted in the same cycle the previous result is taken.

Top module: `nan_screen`

## Requirements
- R1: A used operand that is a signalling NaN raises `flag_invalid`, whatever the class. This includes class 1, the load of a narrower-format value.
- R2: For the arithmetic class (0), the load class (1) and codes 5 to 7, a quiet NaN operand does not raise `flag_invalid`. The result is still forced to the propagated NaN (`force_nan`=1).
- R3: For the compare (2), store-to-integer (3) and store-to-BCD (4) classes, a quiet NaN operand raises `flag_invalid`. If the condition is masked, the result is the propagated NaN.
- R4: Every result emitted with `force_nan`=1 has bit 62 set, so it is quiet. Outside a stack fault, `res_b` equals `res_a`.
- R5: If exactly one used operand is a NaN, that operand is propagated. If both are NaNs, the one with the larger unsigned 64-bit significand is propagated, and operand A wins ties. The sign, the exponent and significand bits other than bit 62 are kept.
- R6: When `stk_fault` is 1 and the condition is masked, `flag_invalid` is raised and both `res_a` and `res_b` hold the indefinite value: sign 1, exponent 0x7FFF, significand 0xC000000000000000.
- R7: When the invalid condition arises with `inv_mask`=0, the stage outputs `exc_req`=1, `no_wb`=1, `force_nan`=0, and both results are zero.
- R8: An operand whose bit in `opnd_use` is 0 has no effect on the flags or the results.
- R9: `flag_invalid` reports the invalid condition regardless of `inv_mask`.
- R10: After reset `out_valid`=0 and `in_ready`=1. Latency is one cycle. The output holds steady while `out_ready`=0, and `in_ready` = !`out_valid` || `out_ready`.
- R11: With no NaN operand and no stack fault, all flags are 0 and both results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Stage can take an operation |
| op_a | input | 80 | First operand |
| op_b | input | 80 | Second operand |
| opnd_use | input | 2 | bit0: A used, bit1: B used |
| op_class | input | 3 | Operation class code |
| inv_mask | input | 1 | 1 = invalid-operation masked |
| stk_fault | input | 1 | Masked stack overflow on a two-result operation |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| flag_invalid | output | 1 | Invalid-operation condition |
| exc_req | output | 1 | Unmasked exception request |
| no_wb | output | 1 | Suppress result writeback |
| force_nan | output | 1 | Result replaced by `res_a`/`res_b` |
| res_a | output | 80 | First result slot |
| res_b | output | 80 | Second result slot |

## Verification
A wrong classification shows up one cycle after acceptance, as a wrong `flag_invalid` or `force_nan` on the matching output beat. A wrong selection between two NaNs shows up at the same point as a wrong significand in `res_a`. A corrupted output register or handshake state shows up as a lost, duplicated or changed beat the first time the consumer stalls. The bench mixes consumer stalls with NaN-heavy operands and compares every accepted beat against a model, so any of these faults appears within one transfer.

// File: rtl/nan_screen_pkg.sv
package nan_screen_pkg;
  typedef enum logic [2:0] {
    CLS_ARITH = 3'd0,
    CLS_LOAD  = 3'd1,
    CLS_CMP   = 3'd2,
    CLS_STINT = 3'd3,
    CLS_STBCD = 3'd4
  } op_class_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } nan_kind_t;
endpackage

// File: rtl/nan_classify.sv
module nan_classify
  import nan_screen_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int W = 1 + EXP_W + SIG_W,
  localparam int QBIT = SIG_W - 2
) (
  input  logic [W-1:0] opnd,
  input  logic         used,
  output nan_kind_t    kind
);
  logic exp_ones, frac_nz;

  always_comb begin
    exp_ones     = &opnd[W-2:SIG_W];
    frac_nz      = |opnd[QBIT:0];
    kind.is_nan  = used && exp_ones && frac_nz;
    kind.is_snan = used && exp_ones && frac_nz && !opnd[QBIT];
  end
endmodule

// File: rtl/nan_pick.sv
module nan_pick
  import nan_screen_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int W = 1 + EXP_W + SIG_W,
  localparam int QBIT = SIG_W - 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  nan_kind_t    ka,
  input  nan_kind_t    kb,
  output logic [W-1:0] quiet_nan,
  output logic         any_nan,
  output logic         any_snan,
  output logic         any_qnan
);
  logic take_a;
  logic [W-1:0] src;

  always_comb begin
    take_a    = ka.is_nan && (!kb.is_nan || (a[SIG_W-1:0] >= b[SIG_W-1:0]));
    src       = take_a ? a : b;
    quiet_nan = src;
    quiet_nan[QBIT] = 1'b1;
    any_nan   = ka.is_nan || kb.is_nan;
    any_snan  = ka.is_snan || kb.is_snan;
    any_qnan  = (ka.is_nan && !ka.is_snan) || (kb.is_nan && !kb.is_snan);
  end
endmodule

// File: rtl/nan_screen.sv
module nan_screen
  import nan_screen_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int W = 1 + EXP_W + SIG_W,
  localparam int NOPS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [NOPS-1:0] opnd_use,
  input  logic [2:0]   op_class,
  input  logic         inv_mask,
  input  logic         stk_fault,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         flag_invalid,
  output logic         exc_req,
  output logic         no_wb,
  output logic         force_nan,
  output logic [W-1:0] res_a,
  output logic [W-1:0] res_b
);
  localparam logic [W-1:0] INDEF = {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};

  logic [W-1:0] opnds [NOPS];
  nan_kind_t    kinds [NOPS];

  assign opnds[0] = op_a;
  assign opnds[1] = op_b;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    nan_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
      .opnd(opnds[i]),
      .used(opnd_use[i]),
      .kind(kinds[i])
    );
  end

  logic [W-1:0] prop_nan;
  logic any_nan, any_snan, any_qnan;

  nan_pick #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_pick (
    .a(op_a), .b(op_b), .ka(kinds[0]), .kb(kinds[1]),
    .quiet_nan(prop_nan), .any_nan(any_nan),
    .any_snan(any_snan), .any_qnan(any_qnan)
  );

  logic strict_cls, inv_d, exc_d, force_d;
  logic [W-1:0] ra_d, rb_d;

  always_comb begin
    strict_cls = (op_class == CLS_CMP) || (op_class == CLS_STINT) ||
                 (op_class == CLS_STBCD);
    inv_d   = any_snan || (strict_cls && any_qnan) || stk_fault;
    exc_d   = inv_d && !inv_mask;
    force_d = !exc_d && (any_nan || stk_fault);
    ra_d    = '0;
    rb_d    = '0;
    if (force_d) begin
      if (stk_fault) begin
        ra_d = INDEF;
        rb_d = INDEF;
      end else begin
        ra_d = prop_nan;
        rb_d = prop_nan;
      end
    end
  end

  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      flag_invalid <= 1'b0;
      exc_req      <= 1'b0;
      no_wb        <= 1'b0;
      force_nan    <= 1'b0;
      res_a        <= '0;
      res_b        <= '0;
    end else begin
      if (take) begin
        out_valid    <= 1'b1;
        flag_invalid <= inv_d;
        exc_req      <= exc_d;
        no_wb        <= exc_d;
        force_nan    <= force_d;
        res_a        <= ra_d;
        res_b        <= rb_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nan_screen_chk.sv
module nan_screen_chk #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64,
  localparam int W = 1 + EXP_W + SIG_W,
  localparam int QBIT = SIG_W - 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic         flag_invalid,
  input logic         exc_req,
  input logic         no_wb,
  input logic         force_nan,
  input logic [W-1:0] res_a,
  input logic [W-1:0] res_b
);
  assert_quiet_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && force_nan) |-> (res_a[QBIT] && res_b[QBIT] && (&res_a[W-2:SIG_W])));

  assert_exc_nowb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exc_req) |-> (no_wb && flag_invalid && !force_nan && res_a == '0));

  assert_exc_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !flag_invalid) |-> !exc_req);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_a) && $stable(res_b) &&
                                   $stable(flag_invalid) && $stable(force_nan)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

bind nan_screen nan_screen_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .flag_invalid(flag_invalid),
  .exc_req(exc_req), .no_wb(no_wb), .force_nan(force_nan),
  .res_a(res_a), .res_b(res_b)
);

// File: tb/nan_screen_test.sv
module nan_screen_test;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0;
  logic [79:0] op_a = '0, op_b = '0, res_a, res_b;
  logic [1:0] opnd_use = '0;
  logic [2:0] op_class = '0;
  logic inv_mask = 0, stk_fault = 0;
  logic flag_invalid, exc_req, no_wb, force_nan;

  always #4 clk = ~clk;

  nan_screen uut (.*);

  int errs = 0, checks = 0, cyc = 0;
  bit stall_en = 0;
  bit last_fire = 0;

  typedef struct {
    logic fl, ex, nw, fn;
    logic [79:0] ra, rb;
    string tag;
  } exp_t;
  exp_t q[$];

  localparam logic [79:0] INDEF = 80'hFFFF_C000_0000_0000_0000;

  function automatic bit isnan(logic [79:0] v);
    return (v[78:64] == 15'h7FFF) && (v[62:0] != 0);
  endfunction

  function automatic exp_t model(logic [79:0] a, logic [79:0] b, logic [1:0] u,
                                 logic [2:0] c, logic m, logic sf, string tag);
    exp_t e;
    bit na, nb, sa, sb, inv, strict;
    logic [79:0] p;
    na = u[0] && isnan(a); nb = u[1] && isnan(b);
    sa = na && !a[62];     sb = nb && !b[62];
    strict = (c == 2) || (c == 3) || (c == 4);
    inv = sa || sb || sf || (strict && ((na && !sa) || (nb && !sb)));
    e.tag = tag; e.fl = inv; e.ex = inv && !m; e.nw = e.ex;
    e.ra = 0; e.rb = 0; e.fn = 0;
    if (!e.ex && (sf || na || nb)) begin
      e.fn = 1;
      if (sf) begin e.ra = INDEF; e.rb = INDEF; end
      else begin
        if (na && nb) p = (b[63:0] > a[63:0]) ? b : a;
        else p = na ? a : b;
        p[62] = 1'b1;
        e.ra = p; e.rb = p;
      end
    end
    return e;
  endfunction

  always @(negedge clk) out_ready <= stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;

  always @(negedge clk) begin
    #2;
    last_fire = in_valid && in_ready;
    if (rst_n && out_valid && out_ready) begin
      checks++;
      if (q.size() == 0) begin
        errs++;
        $display("FAIL R10 unexpected output beat: actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if ({flag_invalid, exc_req, no_wb, force_nan} != {e.fl, e.ex, e.nw, e.fn} ||
            res_a !== e.ra || res_b !== e.rb) begin
          errs++;
          $display("FAIL %s: actual flags=%b ra=%h rb=%h expected flags=%b ra=%h rb=%h",
                   e.tag, {flag_invalid, exc_req, no_wb, force_nan}, res_a, res_b,
                   {e.fl, e.ex, e.nw, e.fn}, e.ra, e.rb);
        end
      end
    end
  end

  task automatic send(logic [79:0] a, logic [79:0] b, logic [1:0] u, logic [2:0] c,
                      logic m, logic sf, string tag);
    @(negedge clk);
    op_a = a; op_b = b; opnd_use = u; op_class = c; inv_mask = m; stk_fault = sf;
    in_valid = 1;
    do @(posedge clk); while (!last_fire);
    q.push_back(model(a, b, u, c, m, sf, tag));
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [79:0] mk(int kind);
    logic [79:0] v;
    v = {$urandom, $urandom, $urandom};
    if (kind == 1) begin v[78:64] = 15'h7FFF; v[62] = 1; end
    else if (kind == 2) begin v[78:64] = 15'h7FFF; v[62] = 0; v[0] = 1; end
    else if (kind == 3) v[78:64] = 15'h7FFF;
    return v;
  endfunction

  localparam logic [79:0] QN1 = 80'h7FFF_C000_0000_0000_0005;
  localparam logic [79:0] QN2 = 80'hFFFF_E000_0000_0000_0000;
  localparam logic [79:0] SN1 = 80'h7FFF_A000_0000_0000_0001;
  localparam logic [79:0] NUM = 80'h3FFF_8000_0000_0000_0000;
  localparam logic [79:0] INF = 80'h7FFF_8000_0000_0000_0000;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 0 || in_ready !== 1) begin
      errs++;
      $display("FAIL R10 reset: actual v=%b r=%b expected v=0 r=1", out_valid, in_ready);
    end
    rst_n = 1;
    send(NUM, INF, 2'b11, 0, 1, 0, "R11 ordinary operands");
    send(SN1, NUM, 2'b11, 0, 1, 0, "R1 snan arith masked");
    send(NUM, SN1, 2'b11, 1, 1, 0, "R1 snan load");
    send(QN1, NUM, 2'b11, 0, 1, 0, "R2 qnan arith silent");
    send(QN1, NUM, 2'b01, 1, 0, 0, "R2 qnan load unmasked");
    send(QN1, NUM, 2'b11, 2, 1, 0, "R3 qnan compare");
    send(NUM, QN1, 2'b11, 3, 1, 0, "R3 qnan store int");
    send(QN1, NUM, 2'b11, 4, 0, 0, "R3 qnan store bcd unmasked");
    send(SN1, NUM, 2'b11, 0, 1, 0, "R4 snan quieted");
    send(QN1, QN2, 2'b11, 0, 1, 0, "R5 larger significand B");
    send(QN2, QN1, 2'b11, 0, 1, 0, "R5 larger significand A");
    send(SN1, {1'b1, SN1[78:0]}, 2'b11, 0, 1, 0, "R5 tie takes A");
    send(NUM, NUM, 2'b11, 0, 1, 1, "R6 stack fault masked");
    send(NUM, NUM, 2'b11, 0, 0, 1, "R7 stack fault unmasked");
    send(SN1, NUM, 2'b11, 2, 0, 0, "R7 snan unmasked");
    send(NUM, SN1, 2'b01, 2, 1, 0, "R8 unused B snan");
    send(QN1, NUM, 2'b10, 3, 0, 0, "R8 unused A qnan");
    send(SN1, NUM, 2'b11, 0, 0, 0, "R9 flag when unmasked");
    stall_en = 1;
    for (int i = 0; i < 300; i++)
      send(mk($urandom_range(0, 3)), mk($urandom_range(0, 3)), 2'($urandom),
           3'($urandom), 1'($urandom), ($urandom_range(0, 7) == 0), "R10 random stall");
    stall_en = 0;
    repeat (5) @(posedge clk);
    checks++;
    if (q.size() != 0) begin
      errs++;
      $display("FAIL R10 beats lost: actual=%0d expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errs++; checks++;
      $display("FAIL R10 watchdog: actual=%0d cycles expected<50000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule